// File: doc/BRIEF.md
# Serial Fault-Snapshot Readout Port

This block lets a host controller read a four-channel fault register over a four-wire serial link. Each channel owns a 2-bit status code in an 8-bit failure register that sits beside this block. The all-ones code means the channel is healthy. The serial clock, the active-low select and the serial input come straight from pins. They are oversampled by a fast system clock, at least eight times the serial clock rate, through two-flop synchronizers. The select line also passes through a glitch filter.

When the host lowers select, the output at once carries a summary flag. The flag is set when any channel holds a code other than all-ones. On the first rising serial clock of the frame, the block takes a snapshot of the live register into its shift register and sends a one-cycle clear to the register. Faults that occur during the read therefore stay stored for the next frame. The eight snapshot bits then leave one per rising edge, and input bits are taken in on falling edges. Once the snapshot has shifted out, the block returns the received bits, so several devices can be chained.

The data output has a separate enable that models a tristate driver. The enable is dropped while select is high, during external reset and during undervoltage. A select edge seen while the serial clock is high counts as a protocol violation, and such a frame never takes a snapshot.

Top module: `fdiag_spi_readout`

## Requirements
- R1: After reset, and whenever the filtered select has returned high, `miso_oe` is 0. `miso` is 0 while `miso_oe` is 0.
- R2: After a filtered select fall with the serial clock low, `miso_oe` is 1. Until the first rising serial clock, `miso` shows the summary flag: 1 when any channel code `fail_reg[2c+1:2c]` differs from 2'b11, and 0 otherwise.
- R3: The first rising serial clock of a good frame copies `fail_reg` into the shift register and raises `fr_clear` for exactly one system cycle. A frame produces no further pulse, and the snapshot holds the value `fail_reg` had in the capture cycle.
- R4: After rising serial clock edge k (k = 1..8), `miso` shows bit D(k-1), where D(i) is `fail_reg[i]` of the snapshot. Bits [1:0] hold channel 4, [3:2] channel 3, [5:4] channel 2 and [7:6] channel 1.
- R5: `mosi_pin` is sampled on each falling serial clock edge. From rising edge 9 onward, `miso` returns the sampled bits in the order they arrived (edge 9 gives the bit of falling edge 1).
- R6: A select pulse of either polarity that lasts fewer than `CSF_CYC` system cycles is ignored. It neither starts nor ends a frame.
- R7: While `ext_rst_n` is 0 or `uv_lo` is 1, `miso_oe` is 0 in the same cycle and any frame is aborted. After release, the port stays idle until the next select fall.
- R8: A filtered select edge that occurs while the serial clock is high gives a one-cycle `proto_err` pulse. A frame opened that way takes no snapshot, gives no `fr_clear` and keeps showing the summary flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_rst_n | input | 1 | External active-low reset, synchronous to clk |
| uv_lo | input | 1 | Undervoltage flag, synchronous to clk, active high |
| sclk_pin | input | 1 | Serial clock pin (asynchronous) |
| csn_pin | input | 1 | Active-low select pin (asynchronous) |
| mosi_pin | input | 1 | Serial data input pin (asynchronous) |
| fail_reg | input | CH_NUM*CODE_W | Live failure register, 2-bit code per channel |
| fr_clear | output | 1 | One-cycle clear to the failure register |
| miso | output | 1 | Serial data output value |
| miso_oe | output | 1 | Output enable of the serial data driver |
| proto_err | output | 1 | One-cycle pulse on a select edge with clock high |

## Verification
The critical overlap is a new fault arriving in the same system cycle as the snapshot clear. The bench models the failure register so that a set wins over a clear. It arms a channel-1 fault that lands exactly on the edge where `fr_clear` acts. The frame that carries the clear must still report the pre-clear snapshot. The next frame must report summary 1 with only the new channel-1 code (0x7F), and the frame after that must report the register fully clear.

// File: rtl/fdspi_pkg.sv
package fdspi_pkg;
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_ARMED = 2'd1,
      FS_SHIFT = 2'd2,
      FS_BAD   = 2'd3
   } fdspi_state_e;
endpackage

// File: rtl/fdspi_sync.sv
module fdspi_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   initial begin : p_prm
      assert (STAGES >= 2) else $error("fdspi_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/fdspi_deglitch.sv
module fdspi_deglitch #(
   parameter int FILT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic fall_p,
   output logic rise_p
);
   localparam int CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC + 1) : 1;

   initial begin : p_prm
      assert (FILT_CYC >= 1) else $error("fdspi_deglitch: FILT_CYC must be at least 1");
   end

   generate
      if (FILT_CYC <= 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl    <= 1'b1;
               fall_p <= 1'b0;
               rise_p <= 1'b0;
            end else begin
               lvl    <= din;
               fall_p <= lvl & ~din;
               rise_p <= ~lvl & din;
            end
         end
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl    <= 1'b1;
               cnt    <= '0;
               fall_p <= 1'b0;
               rise_p <= 1'b0;
            end else begin
               fall_p <= 1'b0;
               rise_p <= 1'b0;
               if (din == lvl) begin
                  cnt <= '0;
               end else if (cnt == CNT_W'(FILT_CYC - 1)) begin
                  lvl    <= din;
                  cnt    <= '0;
                  fall_p <= ~din;
                  rise_p <= din;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   endgenerate

   AST_LVL_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl != $past(lvl)) |-> (lvl == $past(din))); // R6
endmodule

// File: rtl/fdspi_frame_ctrl.sv
module fdspi_frame_ctrl
   import fdspi_pkg::*;
#(
   parameter int CH_NUM = 4,
   parameter int CODE_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     force_off,
   input  logic                     sclk_s,
   input  logic                     mosi_s,
   input  logic                     cs_fall,
   input  logic                     cs_rise,
   input  logic [CH_NUM*CODE_W-1:0] fail_reg,
   output logic                     fr_clear,
   output logic                     miso,
   output logic                     miso_oe,
   output logic                     proto_err
);
   localparam int REG_W = CH_NUM * CODE_W;

   fdspi_state_e     st;
   logic             sclk_q;
   logic [REG_W-1:0] sr;
   logic             dout;
   logic [CH_NUM-1:0] ch_fail;
   logic             summary;
   logic             sclk_rise;
   logic             sclk_fall;

   generate
      for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
         assign ch_fail[c] = ~&fail_reg[c*CODE_W +: CODE_W];
      end
   endgenerate

   assign summary   = |ch_fail;
   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= FS_IDLE;
         sclk_q    <= 1'b0;
         sr        <= '1;
         dout      <= 1'b0;
         fr_clear  <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         sclk_q    <= sclk_s;
         fr_clear  <= 1'b0;
         proto_err <= (cs_fall | cs_rise) & sclk_s & ~force_off;
         if (force_off) begin
            st <= FS_IDLE;
         end else begin
            case (st)
               FS_IDLE: begin
                  if (cs_fall) st <= sclk_s ? FS_BAD : FS_ARMED;
               end
               FS_ARMED: begin
                  if (cs_rise) begin
                     st <= FS_IDLE;
                  end else if (sclk_rise) begin
                     sr       <= fail_reg;
                     dout     <= fail_reg[0];
                     fr_clear <= 1'b1;
                     st       <= FS_SHIFT;
                  end
               end
               FS_SHIFT: begin
                  if (cs_rise) begin
                     st <= FS_IDLE;
                  end else if (sclk_fall) begin
                     sr <= {mosi_s, sr[REG_W-1:1]};
                  end else if (sclk_rise) begin
                     dout <= sr[0];
                  end
               end
               default: begin
                  if (cs_rise) st <= FS_IDLE;
               end
            endcase
         end
      end
   end

   assign miso_oe = (st != FS_IDLE) & ~force_off;
   assign miso    = miso_oe & ((st == FS_SHIFT) ? dout : summary);

   AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fr_clear |=> !fr_clear); // R3
   AST_CLEAR_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      fr_clear |-> ($past(st) == FS_ARMED)); // R3
   AST_BAD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FS_BAD) |-> !fr_clear); // R8
   AST_PROTO_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> ($past(cs_fall) || $past(cs_rise))); // R8
endmodule

// File: rtl/fdiag_spi_readout.sv
module fdiag_spi_readout #(
   parameter int CH_NUM   = 4,
   parameter int CODE_W   = 2,
   parameter int SYNC_STG = 2,
   parameter int CSF_CYC  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ext_rst_n,
   input  logic                     uv_lo,
   input  logic                     sclk_pin,
   input  logic                     csn_pin,
   input  logic                     mosi_pin,
   input  logic [CH_NUM*CODE_W-1:0] fail_reg,
   output logic                     fr_clear,
   output logic                     miso,
   output logic                     miso_oe,
   output logic                     proto_err
);
   localparam int REG_W = CH_NUM * CODE_W;

   initial begin : p_prm
      assert (CH_NUM >= 1)  else $error("fdiag_spi_readout: CH_NUM must be at least 1");
      assert (CODE_W >= 1)  else $error("fdiag_spi_readout: CODE_W must be at least 1");
      assert (REG_W >= 2)   else $error("fdiag_spi_readout: register needs two bits or more");
      assert (CSF_CYC >= 1) else $error("fdiag_spi_readout: CSF_CYC must be at least 1");
   end

   logic [2:0] pins_s;
   logic       csn_f;
   logic       cs_fall;
   logic       cs_rise;
   logic       force_off;

   fdspi_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STG),
      .RST_VAL(3'b010)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({mosi_pin, csn_pin, sclk_pin}),
      .dout (pins_s)
   );

   fdspi_deglitch #(
      .FILT_CYC(CSF_CYC)
   ) u_csflt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pins_s[1]),
      .lvl   (csn_f),
      .fall_p(cs_fall),
      .rise_p(cs_rise)
   );

   assign force_off = ~ext_rst_n | uv_lo;

   fdspi_frame_ctrl #(
      .CH_NUM(CH_NUM),
      .CODE_W(CODE_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_off(force_off),
      .sclk_s   (pins_s[0]),
      .mosi_s   (pins_s[2]),
      .cs_fall  (cs_fall),
      .cs_rise  (cs_rise),
      .fail_reg (fail_reg),
      .fr_clear (fr_clear),
      .miso     (miso),
      .miso_oe  (miso_oe),
      .proto_err(proto_err)
   );

   AST_OE_OFF_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !miso_oe); // R1
   AST_IDLE_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(csn_f) && csn_f) |-> !miso_oe); // R1
   AST_FORCE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> !miso_oe); // R7
   AST_NO_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe |-> !miso); // R1
endmodule

// File: tb/fdiag_spi_readout_bench.sv
module fdiag_spi_readout_bench;
   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_rst_n = 1'b1;
   logic       uv_lo = 1'b0;
   logic       sclk_pin = 1'b0;
   logic       csn_pin = 1'b1;
   logic       mosi_pin = 1'b0;
   logic [7:0] fr_model;
   logic [7:0] nx;
   logic       fr_clear, miso, miso_oe, proto_err;
   logic       ld_en = 1'b0;
   logic [7:0] ld_val = 8'hFF;
   logic       arm_inj = 1'b0;
   logic       inj_done;
   int         n_chk = 0;
   int         n_fail = 0;
   int         clr_cnt = 0;
   int         perr_cnt = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   fdiag_spi_readout u_fdiag_spi_readout (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .uv_lo(uv_lo),
      .sclk_pin(sclk_pin), .csn_pin(csn_pin), .mosi_pin(mosi_pin),
      .fail_reg(fr_model), .fr_clear(fr_clear), .miso(miso),
      .miso_oe(miso_oe), .proto_err(proto_err)
   );

   // failure register model: a new code wins over the clear in the same cycle
   always @(posedge clk) begin
      if (!rst_n) begin
         fr_model <= 8'hFF;
         inj_done <= 1'b0;
      end else begin
         nx = fr_model;
         if (fr_clear) nx = 8'hFF;
         if (ld_en) nx = ld_val;
         if (arm_inj && fr_clear && !inj_done) begin
            nx[7:6] = 2'b01;
            inj_done <= 1'b1;
         end
         fr_model <= nx;
      end
   end

   always @(posedge clk) begin
      if (rst_n && fr_clear) clr_cnt <= clr_cnt + 1;
      if (rst_n && proto_err) perr_cnt <= perr_cnt + 1;
   end

   function automatic logic exp_sum(input logic [7:0] v);
      logic s = 1'b0;
      for (int c = 0; c < 4; c++) if (v[2*c +: 2] != 2'b11) s = 1'b1;
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wcyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_reg(input logic [7:0] v);
      @(negedge clk); ld_en = 1'b1; ld_val = v;
      @(negedge clk); ld_en = 1'b0;
      wcyc(1);
   endtask

   task automatic bit_cycle(input logic txb, input logic expb, input string req);
      sclk_pin = 1'b1;
      wcyc(H/2);
      mosi_pin = txb;
      wcyc(H/2);
      chk(miso === expb, req, int'(miso), int'(expb));
      sclk_pin = 1'b0;
      wcyc(H);
   endtask

   task automatic cs_open();
      csn_pin = 1'b0;
      wcyc(12);
   endtask

   task automatic cs_close();
      csn_pin = 1'b1;
      wcyc(12);
      chk(miso_oe === 1'b0, "R1 oe after select high", int'(miso_oe), 0);
   endtask

   task automatic do_frame(input logic [7:0] exp_d, input logic [7:0] tx, input int nbits);
      int c0;
      cs_open();
      chk(miso_oe === 1'b1, "R2 oe in frame", int'(miso_oe), 1);
      chk(miso === exp_sum(exp_d), "R2 summary", int'(miso), int'(exp_sum(exp_d)));
      c0 = clr_cnt;
      for (int i = 0; i < nbits; i++) begin
         if (i < 8) bit_cycle(tx[i % 8], exp_d[i], "R4 data bit");
         else       bit_cycle(tx[i % 8], tx[i - 8], "R5 chained bit");
      end
      chk(clr_cnt - c0 == 1, "R3 clear pulses", clr_cnt - c0, 1);
      cs_close();
   endtask

   initial begin
      int c0, p0;
      logic [7:0] v, tx;
      void'($urandom(32'h5EED_0042));
      wcyc(5);
      rst_n = 1'b1;
      wcyc(3);
      chk(miso_oe === 1'b0, "R1 reset oe", int'(miso_oe), 0);
      chk(fr_clear === 1'b0, "R3 reset clear", int'(fr_clear), 0);
      chk(proto_err === 1'b0, "R8 reset proto", int'(proto_err), 0);

      // healthy register, then single channel-4 fault (bits 1:0)
      do_frame(fr_model, 8'hA5, 8);
      set_reg(8'hFE);
      do_frame(8'hFE, 8'h3C, 16);
      chk(fr_model == 8'hFF, "R3 register cleared after read", int'(fr_model), 255);
      do_frame(8'hFF, 8'h00, 8);

      // random contents and chained data
      for (int k = 0; k < 6; k++) begin
         v  = 8'($urandom);
         tx = 8'($urandom);
         set_reg(v);
         do_frame(v, tx, (k % 2 == 0) ? 16 : 10);
      end

      // new fault lands on the same edge as the clear
      set_reg(8'h3F);
      arm_inj = 1'b1;
      do_frame(8'h3F, 8'h96, 8);
      arm_inj = 1'b0;
      chk(inj_done === 1'b1, "R3 fault coincided with clear", int'(inj_done), 1);
      do_frame(8'h7F, 8'h69, 8);
      do_frame(8'hFF, 8'h0F, 8);

      // short select pulses while idle
      csn_pin = 1'b0; wcyc(2); csn_pin = 1'b1; wcyc(12);
      chk(miso_oe === 1'b0, "R6 short low pulse ignored", int'(miso_oe), 0);
      csn_pin = 1'b0; wcyc(3); csn_pin = 1'b1; wcyc(12);
      chk(miso_oe === 1'b0, "R6 three-cycle pulse ignored", int'(miso_oe), 0);

      // short high pulse inside a frame
      set_reg(8'hD7);
      cs_open();
      bit_cycle(1'b0, 1'b1, "R4 bit0");
      csn_pin = 1'b1; wcyc(3); csn_pin = 1'b0; wcyc(12);
      chk(miso_oe === 1'b1, "R6 frame survives glitch", int'(miso_oe), 1);
      for (int i = 1; i < 8; i++) bit_cycle(1'b0, v[0] ^ v[0] ^ logic'(8'hD7 >> i), "R6 data after glitch");
      cs_close();

      // undervoltage before the first clock
      set_reg(8'hEB);
      cs_open();
      c0 = clr_cnt;
      @(negedge clk); uv_lo = 1'b1; #1;
      chk(miso_oe === 1'b0, "R7 undervoltage drops oe", int'(miso_oe), 0);
      wcyc(3); uv_lo = 1'b0; wcyc(4);
      chk(miso_oe === 1'b0, "R7 stays idle after release", int'(miso_oe), 0);
      sclk_pin = 1'b1; wcyc(H); sclk_pin = 1'b0; wcyc(H);
      chk(clr_cnt == c0, "R7 no capture after abort", clr_cnt - c0, 0);
      cs_close();
      do_frame(8'hEB, 8'h11, 8);

      // external reset mid-frame
      set_reg(8'hBE);
      cs_open();
      bit_cycle(1'b1, 1'b0, "R4 bit0");
      bit_cycle(1'b0, 1'b1, "R4 bit1");
      @(negedge clk); ext_rst_n = 1'b0; #1;
      chk(miso_oe === 1'b0, "R7 ext reset drops oe", int'(miso_oe), 0);
      wcyc(4); ext_rst_n = 1'b1; wcyc(4);
      chk(miso_oe === 1'b0, "R7 frame stays aborted", int'(miso_oe), 0);
      cs_close();

      // clock high while select falls
      set_reg(8'hCF);
      p0 = perr_cnt; c0 = clr_cnt;
      sclk_pin = 1'b1; wcyc(4);
      cs_open();
      chk(perr_cnt - p0 == 1, "R8 proto pulse on fall", perr_cnt - p0, 1);
      chk(miso_oe === 1'b1, "R8 bad frame drives", int'(miso_oe), 1);
      sclk_pin = 1'b0; wcyc(H);
      bit_cycle(1'b1, 1'b1, "R8 summary kept");
      bit_cycle(1'b0, 1'b1, "R8 summary kept");
      chk(clr_cnt == c0, "R8 no clear in bad frame", clr_cnt - c0, 0);
      cs_close();
      chk(fr_model == 8'hCF, "R8 register untouched", int'(fr_model), 207);

      // clock high while select rises
      cs_open();
      bit_cycle(1'b0, 1'b1, "R4 bit0");
      p0 = perr_cnt;
      sclk_pin = 1'b1; wcyc(2);
      csn_pin = 1'b1; wcyc(12);
      chk(perr_cnt - p0 == 1, "R8 proto pulse on rise", perr_cnt - p0, 1);
      chk(miso_oe === 1'b0, "R1 oe off after rise", int'(miso_oe), 0);
      sclk_pin = 1'b0; wcyc(H);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule